// File: doc/BRIEF.md
# Serial FPGA Configuration Streamer

This block loads a bitstream into an FPGA through its slave-serial configuration port. It drives the port as an 8-bit pin vector that advances one pattern per pin-update tick. The tick comes from a clock-enable divider. A start pulse begins each load, and a load has four stages in fixed order:

1. A termination preamble stops whatever the target is currently running.
2. A program pulse is sent.
3. The INIT line is polled, with a bounded number of retries.
4. The bitstream is streamed, most significant bit first.

Bitstream bytes arrive on a valid/ready stream that carries a last-byte marker. Each byte is XORed with a key taken from a nonlinear 32-bit state word before it is shifted out. The modulo-177 step of the key update runs bit-serially by default, so input ready stays low until the next key exists.

Busy, done and error flags report progress. The error flag is set when INIT never rises, or when the image exceeds a byte limit. The block sits between a bitstream source and the configuration pins.

Top module: `fpga_cfg_streamer`

## Requirements
- R1: After reset the pins read 0x01 (configuration clock line high, which is idle at the target), and busy, done, error and s_ready_o are all low. At most one of busy, done and error is high at any time.
- R2: Pin vector bits: 0 is the configuration clock, 1 is the program line, 6 is serial data, and 2, 3, 4 and 7 are auxiliary lines. Bit 5 is the INIT input position and is always driven 0.
- R3: After start, the first 16 patterns are the termination preamble. Every pattern has bit 7 set. Patterns k = 2, 4 and 6 (counting k modulo 8 from 0) add bit 3, which gives 0x88. All other patterns add bit 2, which gives 0x84.
- R4: The next 10 patterns are the program pulse: 0x01, 0x03, 0x03, then 0x01 seven times.
- R5: INIT is sampled on the tick after the program pulse, and again every RETRY_GAP ticks, up to RETRY_MAX samples. The first high sample raises s_ready_o on that tick.
- R6: If all RETRY_MAX samples are low, the error flag rises on the tick of the last sample, busy falls and the pins read 0x01.
- R7: Byte n (counting from 1) is XORed with the low byte of the key state after n updates. The state starts at 0x3F6DF2AB, and each update is s = ((s + 0x0A853753) mod 177) + s × 0x08034052, computed in 32 bits.
- R8: Each descrambled byte is sent MSB first, two patterns per bit: data with the clock line high, then the same data with the clock line low. The data bit changes only in a cycle where the clock line is high.
- R9: s_ready_o is high only while the block waits for a byte and its key is ready. Stream input offered at any other time is not taken.
- R10: After the final bit of a byte marked last, the pins return to 0x01 on the next tick and done rises.
- R11: Up to MAX_BYTES bytes are accepted. Accepting one more byte raises the error flag instead of shifting it.
- R12: Each pattern holds for TICK_DIV clocks. The first pattern appears TICK_DIV clocks after the start edge.
- R13: A start pulse while idle, done or in error restarts the whole sequence and reseeds the key state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a configuration run |
| init_i | input | 1 | INIT line from the target |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Byte is the final one of the image |
| s_ready_o | output | 1 | Byte accepted when high with valid |
| pins_o | output | 8 | Configuration pin vector |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Image fully sent |
| err_o | output | 1 | INIT timeout or oversize image |

## Verification
The assertions check properties that must hold on every cycle:
- the status flags are mutually exclusive;
- the INIT bit position is never driven;
- data changes only with the clock line high;
- ready implies busy, and the program line only pulses before data;
- the idle pin pattern holds in the done and error states.

Some behaviours need known stimulus, so only the directed scenarios can show them:
- the exact preamble and program-pulse patterns and their tick timing;
- the INIT retry spacing and the cycle the error appears;
- the descrambled bit order;
- the byte limit boundary;
- reseeding on restart.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_KILL, ST_PROG, ST_WAIT, ST_LOAD, ST_SHIFT, ST_FIN, ST_DONE, ST_ERR
   } cfg_state_e;

   localparam int PIN_CCLK = 0;
   localparam int PIN_PROG = 1;
   localparam int PIN_DIN  = 6;
   localparam logic [7:0] PAT_IDLE = 8'h01;
   localparam logic [3:0] KILL_LAST = 4'd15;
   localparam logic [3:0] PROG_LAST = 4'd9;

   // termination preamble: aux bit 7 always, aux bit 3 on slots 2/4/6 of each group, else aux bit 2
   function automatic logic [7:0] kill_pat(input logic [3:0] k);
      logic alt;
      alt = (k[0] == 1'b0) && (k[2:0] != 3'd0);
      return alt ? 8'h88 : 8'h84;
   endfunction

   // program pulse: clock high throughout, program line high on slots 1 and 2
   function automatic logic [7:0] prog_pat(input logic [3:0] k);
      return (k == 4'd1 || k == 4'd2) ? 8'h03 : 8'h01;
   endfunction
endpackage

// File: rtl/cfgs_tick_gen.sv
module cfgs_tick_gen #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin
      if (DIV < 1) $fatal(1, "cfgs_tick_gen: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_count
         logic [W-1:0] cnt;
         assign tick_o = (cnt == W'(DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)                cnt <= '0;
            else if (clr_i || tick_o)  cnt <= '0;
            else                       cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cfgs_descrambler.sv
module cfgs_descrambler #(
   parameter bit          SERIAL  = 1'b1,
   parameter logic [31:0] SEED    = 32'h3F6DF2AB,
   parameter logic [31:0] ADDEND  = 32'h0A853753,
   parameter logic [31:0] FACTOR  = 32'h08034052,
   parameter int          MODULUS = 177
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seed_i,
   input  logic       next_i,
   output logic [7:0] key_o,
   output logic       rdy_o
);
   localparam int MW = $clog2(MODULUS);

   initial begin
      if (MODULUS < 2 || MODULUS > 65535) $fatal(1, "cfgs_descrambler: MODULUS out of range");
   end

   logic [31:0] st_q;
   logic        rdy_q;

   assign key_o = st_q[7:0];
   assign rdy_o = rdy_q;

   generate
      if (SERIAL) begin : g_serial
         // restoring remainder, one dividend bit per clock
         logic [31:0]   dvd;
         logic [MW-1:0] rem;
         logic [MW:0]   trial;
         logic [MW:0]   rem_n;
         logic [4:0]    step;
         logic          run;

         assign trial = {rem, dvd[31]};
         assign rem_n = (trial >= (MW+1)'(MODULUS)) ? trial - (MW+1)'(MODULUS) : trial;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_q <= SEED; rdy_q <= 1'b0; run <= 1'b0;
               dvd <= '0; rem <= '0; step <= '0;
            end else if (seed_i) begin
               st_q <= SEED; dvd <= SEED + ADDEND; rem <= '0;
               step <= '0; run <= 1'b1; rdy_q <= 1'b0;
            end else if (next_i) begin
               dvd <= st_q + ADDEND; rem <= '0;
               step <= '0; run <= 1'b1; rdy_q <= 1'b0;
            end else if (run) begin
               dvd  <= dvd << 1;
               rem  <= rem_n[MW-1:0];
               step <= step + 1'b1;
               if (step == 5'd31) begin
                  run   <= 1'b0;
                  rdy_q <= 1'b1;
                  st_q  <= 32'(rem_n) + st_q * FACTOR;
               end
            end
         end
      end else begin : g_single
         function automatic logic [31:0] step_fn(input logic [31:0] s);
            logic [31:0] a;
            a = s + ADDEND;
            return (a % 32'(MODULUS)) + s * FACTOR;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_q <= SEED; rdy_q <= 1'b0;
            end else if (seed_i) begin
               st_q <= step_fn(SEED); rdy_q <= 1'b1;
            end else if (next_i) begin
               st_q <= step_fn(st_q);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fpga_cfg_streamer.sv
module fpga_cfg_streamer
   import cfgs_pkg::*;
#(
   parameter int TICK_DIV   = 100,     // 75 MHz clock -> 750 kHz pin rate
   parameter int RETRY_MAX  = 10,
   parameter int RETRY_GAP  = 7500,    // ticks between INIT samples (10 ms at 750 kHz)
   parameter int MAX_BYTES  = 262144,
   parameter bit SERIAL_MOD = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       init_i,
   input  logic [7:0] s_data_i,
   input  logic       s_valid_i,
   input  logic       s_last_i,
   output logic       s_ready_o,
   output logic [7:0] pins_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       err_o
);
   localparam int RW = $clog2(RETRY_MAX);
   localparam int GW = $clog2(RETRY_GAP);
   localparam int CW = $clog2(MAX_BYTES + 1);

   initial begin
      if (RETRY_MAX < 2) $fatal(1, "fpga_cfg_streamer: RETRY_MAX must be >= 2");
      if (RETRY_GAP < 2) $fatal(1, "fpga_cfg_streamer: RETRY_GAP must be >= 2");
      if (MAX_BYTES < 1) $fatal(1, "fpga_cfg_streamer: MAX_BYTES must be >= 1");
   end

   cfg_state_e    st;
   logic [3:0]    idx;
   logic [RW-1:0] retry;
   logic [GW-1:0] gap;
   logic [CW-1:0] nbytes;
   logic [7:0]    shreg;
   logic [2:0]    bitn;
   logic          phase, last_q;
   logic          tick, key_rdy, launch, accept, idle_like;
   logic [7:0]    key;

   assign idle_like = (st == ST_IDLE) || (st == ST_DONE) || (st == ST_ERR);
   assign launch    = start_i && idle_like;
   assign s_ready_o = (st == ST_LOAD) && key_rdy;
   assign accept    = s_ready_o && s_valid_i;
   assign busy_o    = !idle_like;
   assign done_o    = (st == ST_DONE);
   assign err_o     = (st == ST_ERR);

   cfgs_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr_i(launch), .tick_o(tick)
   );

   cfgs_descrambler #(.SERIAL(SERIAL_MOD)) u_key (
      .clk(clk), .rst_n(rst_n), .seed_i(launch), .next_i(accept),
      .key_o(key), .rdy_o(key_rdy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE; pins_o <= PAT_IDLE; idx <= '0; retry <= '0; gap <= '0;
         nbytes <= '0; shreg <= '0; bitn <= '0; phase <= 1'b0; last_q <= 1'b0;
      end else if (launch) begin
         st <= ST_KILL; idx <= '0; nbytes <= '0;
      end else begin
         case (st)
            ST_KILL: if (tick) begin
               pins_o <= kill_pat(idx);
               if (idx == KILL_LAST) begin st <= ST_PROG; idx <= '0; end
               else idx <= idx + 1'b1;
            end
            ST_PROG: if (tick) begin
               pins_o <= prog_pat(idx);
               if (idx == PROG_LAST) begin
                  st <= ST_WAIT; retry <= '0; gap <= '0;
               end else idx <= idx + 1'b1;
            end
            ST_WAIT: if (tick) begin
               if (gap != '0)                        gap <= gap - 1'b1;
               else if (init_i)                      st <= ST_LOAD;
               else if (retry == RW'(RETRY_MAX - 1)) st <= ST_ERR;
               else begin
                  retry <= retry + 1'b1;
                  gap   <= GW'(RETRY_GAP - 1);
               end
            end
            ST_LOAD: if (accept) begin
               if (nbytes == CW'(MAX_BYTES)) begin
                  st <= ST_ERR; pins_o <= PAT_IDLE;
               end else begin
                  shreg <= s_data_i ^ key; last_q <= s_last_i;
                  nbytes <= nbytes + 1'b1; bitn <= 3'd7; phase <= 1'b0;
                  st <= ST_SHIFT;
               end
            end
            ST_SHIFT: if (tick) begin
               pins_o <= '0;
               pins_o[PIN_DIN]  <= shreg[bitn];
               pins_o[PIN_CCLK] <= !phase;
               phase <= !phase;
               if (phase) begin
                  if (bitn != 3'd0) bitn <= bitn - 1'b1;
                  else              st <= last_q ? ST_FIN : ST_LOAD;
               end
            end
            ST_FIN: if (tick) begin
               pins_o <= PAT_IDLE; st <= ST_DONE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] pins_o,
   input logic       s_ready_o,
   input logic       busy_o,
   input logic       done_o,
   input logic       err_o
);
   p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_o, done_o, err_o}));

   p_init_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pins_o[5] == 1'b0);

   p_prog_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pins_o[1] |-> (busy_o && !s_ready_o));

   p_err_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (pins_o == 8'h01));

   p_din_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pins_o[6]) |-> pins_o[0]);

   p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> busy_o);

   p_done_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pins_o == 8'h01));
endmodule

bind fpga_cfg_streamer cfgs_checker u_chk (
   .clk(clk), .rst_n(rst_n), .pins_o(pins_o), .s_ready_o(s_ready_o),
   .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/fpga_cfg_streamer_tb_top.sv
module fpga_cfg_streamer_tb_top;
   localparam int D   = 4;
   localparam int RM  = 3;
   localparam int RG  = 5;
   localparam int MAX = 4;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, init = 1'b0;
   logic [7:0] sdata = '0;
   logic svalid = 1'b0, slast = 1'b0;
   logic sready, busy, done, err;
   logic [7:0] pins;

   int checks = 0, errors = 0;
   int fall_n = 0;
   logic bit_log [0:255];
   logic [7:0] prev_pins = 8'h01;

   always #4 clk = !clk;

   fpga_cfg_streamer #(.TICK_DIV(D), .RETRY_MAX(RM), .RETRY_GAP(RG),
                       .MAX_BYTES(MAX), .SERIAL_MOD(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .init_i(init),
      .s_data_i(sdata), .s_valid_i(svalid), .s_last_i(slast), .s_ready_o(sready),
      .pins_o(pins), .busy_o(busy), .done_o(done), .err_o(err)
   );

   // record data pin on every falling edge of the configuration clock line
   always @(negedge clk) begin
      if (prev_pins[0] && !pins[0]) begin
         bit_log[fall_n % 256] = pins[6];
         fall_n = fall_n + 1;
      end
      prev_pins = pins;
   end

   function automatic logic [31:0] key_step(input logic [31:0] s);
      logic [31:0] a;
      a = s + 32'h0A853753;
      return (a % 32'd177) + s * 32'h08034052;
   endfunction

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * D) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic last);
      @(negedge clk);
      sdata = b; slast = last; svalid = 1'b1;
      while (!sready) @(negedge clk);
      @(negedge clk);
      svalid = 1'b0; slast = 1'b0;
   endtask

   task automatic wait_end();
      while (!done && !err) @(negedge clk);
   endtask

   task automatic t_reset();
      check(pins == 8'h01, "R1 reset pins", pins, 8'h01);
      check({busy, done, err, sready} == 4'b0, "R1 reset flags", {busy, done, err, sready}, 0);
   endtask

   // preamble, program pulse, tick timing, retry exhaustion; stream offered throughout
   task automatic t_preamble_timeout();
      logic [7:0] exp;
      int bad;
      init = 1'b0; svalid = 1'b1; sdata = 8'h5A;
      do_start();
      check(busy == 1'b1, "R13 busy after start", busy, 1);
      repeat (D - 1) @(negedge clk);
      check(pins == 8'h01, "R12 pattern not before tick", pins, 8'h01);
      @(negedge clk);
      bad = 0;
      for (int k = 0; k < 26; k++) begin
         if (k > 0) wait_ticks(1);
         if (k < 16) exp = ((k % 8) inside {2, 4, 6}) ? 8'h88 : 8'h84;
         else        exp = ((k - 16) inside {1, 2}) ? 8'h03 : 8'h01;
         if (k < 16) check(pins == exp, "R3 preamble pattern", pins, exp);
         else        check(pins == exp, "R4 program pattern", pins, exp);
         if (sready) bad++;
      end
      check(bad == 0, "R9 no ready during preamble", bad, 0);
      wait_ticks(36 - 26);
      check(err == 1'b0, "R5 no error before last sample", err, 0);
      wait_ticks(1);
      check(err == 1'b1, "R6 error on last sample", err, 1);
      check(busy == 1'b0 && pins == 8'h01, "R6 idle after error", {busy, pins}, 8'h01);
      svalid = 1'b0;
   endtask

   task automatic run_data(input logic [7:0] b [0:7], input int n, input string tag);
      logic [31:0] s;
      logic [7:0] exp;
      int base, bad;
      init = 1'b1;
      base = fall_n;
      do_start();
      for (int i = 0; i < n; i++) send_byte(b[i], i == n - 1);
      wait_end();
      check(done == 1'b1 && err == 1'b0, {tag, " R10 done"}, {done, err}, 2);
      check(pins == 8'h01, {tag, " R10 idle pins"}, pins, 8'h01);
      check(fall_n - base == 1 + 8 * n, {tag, " R8 clock count"}, fall_n - base, 1 + 8 * n);
      s = 32'h3F6DF2AB;
      bad = 0;
      for (int i = 0; i < n; i++) begin
         s = key_step(s);
         exp = b[i] ^ s[7:0];
         for (int j = 0; j < 8; j++)
            if (bit_log[(base + 1 + 8 * i + j) % 256] !== exp[7 - j]) bad++;
      end
      check(bad == 0, {tag, " R7 descrambled MSB-first bits"}, bad, 0);
   endtask

   task automatic t_late_init();
      logic [7:0] b [0:7];
      init = 1'b0;
      do_start();
      wait_ticks(29);
      init = 1'b1;
      wait_ticks(2);
      check(sready == 1'b0, "R5 ready waits for sample", sready, 0);
      wait_ticks(1);
      check(sready == 1'b1, "R5 ready on second sample", sready, 1);
      b = '{8'h81, 0, 0, 0, 0, 0, 0, 0};
      send_byte(b[0], 1'b1);
      wait_end();
      check(done == 1'b1, "R5 late init completes", done, 1);
   endtask

   task automatic t_oversize();
      int base;
      init = 1'b1;
      base = fall_n;
      do_start();
      for (int i = 0; i < MAX + 1; i++) send_byte(8'(i * 17), 1'b0);
      wait_end();
      check(err == 1'b1 && done == 1'b0, "R11 oversize error", {err, done}, 2);
      check(fall_n - base == 1 + 8 * MAX, "R11 only limit shifted", fall_n - base, 1 + 8 * MAX);
   endtask

   initial begin
      logic [7:0] b [0:7];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_preamble_timeout();
      b = '{8'h00, 8'hFF, 8'hA5, 0, 0, 0, 0, 0};
      run_data(b, 3, "run3");
      b = '{8'h3C, 0, 0, 0, 0, 0, 0, 0};
      run_data(b, 1, "R13 restart");
      t_late_init();
      b = '{8'h12, 8'h34, 8'h56, 8'h78, 0, 0, 0, 0};
      run_data(b, MAX, "R11 at limit");
      t_oversize();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule